// File: doc/BRIEF.md
# Packet Timestamp Capture Buffer

This block holds one captured time value for the receive path and one for the transmit path. Both buffers are fed by a free-running 64-bit time counter. Upstream packet classification supplies, for each direction, one qualified event strobe together with a 2-bit event class and a 16-bit sequence identifier. If the class is enabled for that direction and the buffer is empty, the buffer takes the counter value of that same cycle and the sequence identifier. It then sets its valid flag and stays frozen until the host clears it.

The host reaches the buffers through a small word-addressed register file. Address bit 2 selects the direction: 0 is receive and 1 is transmit. Address bits 1:0 select the register within that direction: 0 is status, 1 is timestamp low word, 2 is timestamp high word and 3 is the class enable mask. Writes take effect on the clock edge. Read data is combinational from the address. The host clears a buffer by writing its status register with bit 16 set, which it can do at any time, for example after it reprograms the classification rules.

Top module: `ts_cap_top`

## Requirements
- R1: After reset, every register of both directions reads 0: valid flag clear, timestamp words zero and enable masks zero.
- R2: A qualifying event captures the `time_cnt` value present in the strobe cycle. From the next cycle the low word (address offset 1) reads `time_cnt[31:0]` and the high word (offset 2) reads `time_cnt[63:32]`.
- R3: The status register (offset 0) reads the sequence identifier captured with the event in bits 15:0 and the valid flag in bit 16, with bits 31:17 zero.
- R4: While the valid flag is set, further events on that direction change neither the timestamp nor the sequence identifier.
- R5: A status write with bit 16 set clears the valid flag on the next cycle. A status write with bit 16 clear has no effect.
- R6: When a clear and a qualifying event fall in the same cycle, the clear is applied first and the event is then captured. The buffer ends up valid, holding the new time value and sequence identifier.
- R7: An event of class c (0..2) qualifies only when bit c of that direction's enable mask is set. A mask of 7 enables all classes, a mask of 0 disables capture, and class 3 never qualifies.
- R8: The receive and transmit buffers are independent. Captures, clears and enable writes on one direction leave the other direction's registers unchanged.
- R9: The enable register (offset 3) stores write data bits 2:0 and reads them back with all upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_cnt | input | 64 | Free-running time counter |
| rx_evt | input | 1 | Receive qualified event strobe |
| rx_cls | input | 2 | Receive event class |
| rx_seq | input | 16 | Receive sequence identifier |
| tx_evt | input | 1 | Transmit qualified event strobe |
| tx_cls | input | 2 | Transmit event class |
| tx_seq | input | 16 | Transmit sequence identifier |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |

## Verification
Two functions can land on the same edge: the host's clear write and a new event strobe on the same direction. The clear must win first and the event must still be captured. The bench forces this collision directly on a full buffer, and then creates it many more times by issuing random clear writes alongside random strobes. Each such cycle is judged by reading the status and both timestamp words and comparing them with a bench model that applies the clear before the capture.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int REG_W     = 32;
  localparam int TS_W      = 2 * REG_W;
  localparam int SEQ_W     = 16;
  localparam int VALID_BIT = 16;
  localparam int NDIR      = 2;
  localparam int NCLASS    = 3;
  localparam int CLS_W     = 2;
  localparam int ADDR_W    = 3;
  localparam int DIR_BIT   = 2;

  typedef enum logic [1:0] {
    RG_STATUS = 2'd0,
    RG_TS_LO  = 2'd1,
    RG_TS_HI  = 2'd2,
    RG_ENABLE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ts_cap_slot.sv
module ts_cap_slot
  import ts_cap_pkg::*;
#(
  parameter int P_TS_W   = TS_W,
  parameter int P_SEQ_W  = SEQ_W,
  parameter int P_NCLASS = NCLASS,
  parameter int P_CLS_W  = CLS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt,
  input  logic [P_CLS_W-1:0]  evt_cls,
  input  logic [P_SEQ_W-1:0]  evt_seq,
  input  logic [P_TS_W-1:0]   time_cnt,
  input  logic [P_NCLASS-1:0] en_mask,
  input  logic                clr,
  output logic                valid_q,
  output logic [P_TS_W-1:0]   ts_q,
  output logic [P_SEQ_W-1:0]  seq_q
);
  logic [P_NCLASS-1:0] en_shift;
  logic                qual;
  logic                cap;
  logic                valid_d;
  logic                valid_ce;

  // next-state
  always_comb begin
    en_shift = en_mask >> evt_cls;
    qual     = evt && en_shift[0];
    cap      = qual && (!valid_q || clr);
    valid_ce = cap || clr;
    if (cap)
      valid_d = 1'b1;
    else
      valid_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (valid_ce) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q  <= '0;
      seq_q <= '0;
    end else if (cap) begin
      ts_q  <= time_cnt;
      seq_q <= evt_seq;
    end
  end
endmodule

// File: rtl/ts_cap_regfile.sv
module ts_cap_regfile
  import ts_cap_pkg::*;
#(
  parameter int P_NDIR   = NDIR,
  parameter int P_REG_W  = REG_W,
  parameter int P_SEQ_W  = SEQ_W,
  parameter int P_NCLASS = NCLASS,
  parameter int P_ADDR_W = ADDR_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              host_wr,
  input  logic [P_ADDR_W-1:0]               host_addr,
  input  logic [P_REG_W-1:0]                host_wdata,
  input  logic [P_NDIR-1:0]                 valid_i,
  input  logic [P_NDIR-1:0][2*P_REG_W-1:0]  ts_i,
  input  logic [P_NDIR-1:0][P_SEQ_W-1:0]    seq_i,
  output logic [P_NDIR-1:0]                 clr_o,
  output logic [P_NDIR-1:0][P_NCLASS-1:0]   en_o,
  output logic [P_REG_W-1:0]                host_rdata
);
  localparam int PAD_W = P_REG_W - P_SEQ_W - 1;
  localparam int EPAD  = P_REG_W - P_NCLASS;

  reg_sel_e rsel;
  logic     dsel;

  assign rsel = reg_sel_e'(host_addr[1:0]);
  assign dsel = host_addr[DIR_BIT];

  for (genvar d = 0; d < P_NDIR; d++) begin : g_dir
    logic hit;
    logic en_we;
    logic [P_NCLASS-1:0] en_q;

    assign hit      = host_wr && (dsel == 1'(d));
    assign clr_o[d] = hit && (rsel == RG_STATUS) && host_wdata[VALID_BIT];
    assign en_we    = hit && (rsel == RG_ENABLE);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= '0;
      end else if (en_we) begin
        en_q <= host_wdata[P_NCLASS-1:0];
      end
    end
    assign en_o[d] = en_q;
  end

  always_comb begin
    unique case (rsel)
      RG_STATUS: host_rdata = {{PAD_W{1'b0}}, valid_i[dsel], seq_i[dsel]};
      RG_TS_LO:  host_rdata = ts_i[dsel][P_REG_W-1:0];
      RG_TS_HI:  host_rdata = ts_i[dsel][2*P_REG_W-1:P_REG_W];
      default:   host_rdata = {{EPAD{1'b0}}, en_o[dsel]};
    endcase
  end
endmodule

// File: rtl/ts_cap_top.sv
module ts_cap_top
  import ts_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   time_cnt,
  input  logic              rx_evt,
  input  logic [CLS_W-1:0]  rx_cls,
  input  logic [SEQ_W-1:0]  rx_seq,
  input  logic              tx_evt,
  input  logic [CLS_W-1:0]  tx_cls,
  input  logic [SEQ_W-1:0]  tx_seq,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NDIR-1:0]              evt_arr;
  logic [NDIR-1:0][CLS_W-1:0]   cls_arr;
  logic [NDIR-1:0][SEQ_W-1:0]   seqin_arr;
  logic [NDIR-1:0]              slot_valid;
  logic [NDIR-1:0][TS_W-1:0]    slot_ts;
  logic [NDIR-1:0][SEQ_W-1:0]   slot_seq;
  logic [NDIR-1:0]              slot_clr;
  logic [NDIR-1:0][NCLASS-1:0]  slot_en;

  assign evt_arr   = {tx_evt, rx_evt};
  assign cls_arr   = {tx_cls, rx_cls};
  assign seqin_arr = {tx_seq, rx_seq};

  for (genvar d = 0; d < NDIR; d++) begin : g_slot
    ts_cap_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .evt      (evt_arr[d]),
      .evt_cls  (cls_arr[d]),
      .evt_seq  (seqin_arr[d]),
      .time_cnt (time_cnt),
      .en_mask  (slot_en[d]),
      .clr      (slot_clr[d]),
      .valid_q  (slot_valid[d]),
      .ts_q     (slot_ts[d]),
      .seq_q    (slot_seq[d])
    );
  end

  ts_cap_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .valid_i    (slot_valid),
    .ts_i       (slot_ts),
    .seq_i      (slot_seq),
    .clr_o      (slot_clr),
    .en_o       (slot_en),
    .host_rdata (host_rdata)
  );
endmodule

// File: rtl/ts_cap_chk.sv
module ts_cap_chk
  import ts_cap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [TS_W-1:0]   time_cnt,
  input logic              rx_evt,
  input logic [CLS_W-1:0]  rx_cls,
  input logic              tx_evt,
  input logic [CLS_W-1:0]  tx_cls,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [REG_W-1:0]  host_wdata,
  input logic              rx_valid,
  input logic              tx_valid,
  input logic [TS_W-1:0]   rx_ts,
  input logic [TS_W-1:0]   tx_ts,
  input logic [NCLASS-1:0] rx_en,
  input logic [NCLASS-1:0] tx_en
);
  logic [NCLASS-1:0] rx_sh, tx_sh;
  logic rx_q, tx_q, rx_wclr, tx_wclr;

  assign rx_sh   = rx_en >> rx_cls;
  assign tx_sh   = tx_en >> tx_cls;
  assign rx_q    = rx_evt && rx_sh[0];
  assign tx_q    = tx_evt && tx_sh[0];
  assign rx_wclr = host_wr && host_addr == 3'd0 && host_wdata[VALID_BIT];
  assign tx_wclr = host_wr && host_addr == 3'd4 && host_wdata[VALID_BIT];

  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_q && (!rx_valid || rx_wclr) |=> rx_valid && rx_ts == $past(time_cnt)); // R2
  AST_TX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_q && (!tx_valid || tx_wclr) |=> tx_valid && tx_ts == $past(time_cnt)); // R2
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_wclr |=> rx_valid && $stable(rx_ts)); // R4
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_wclr |=> tx_valid && $stable(tx_ts)); // R4
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wclr && !rx_q |=> !rx_valid); // R5
  AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wclr && !tx_q |=> !tx_valid); // R5
  AST_RX_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid && !rx_q |=> !rx_valid); // R7
  AST_TX_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid && !tx_q |=> !tx_valid); // R7
endmodule

bind ts_cap_top ts_cap_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .time_cnt   (time_cnt),
  .rx_evt     (rx_evt),
  .rx_cls     (rx_cls),
  .tx_evt     (tx_evt),
  .tx_cls     (tx_cls),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .rx_valid   (slot_valid[0]),
  .tx_valid   (slot_valid[1]),
  .rx_ts      (slot_ts[0]),
  .tx_ts      (slot_ts[1]),
  .rx_en      (slot_en[0]),
  .tx_en      (slot_en[1])
);

// File: tb/ts_cap_top_tb.sv
module ts_cap_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [63:0] time_cnt;
  logic        rx_evt, tx_evt;
  logic [1:0]  rx_cls, tx_cls;
  logic [15:0] rx_seq, tx_seq;
  logic        host_wr;
  logic [2:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model, index 0 = receive, 1 = transmit
  bit          m_v  [2];
  logic [63:0] m_ts [2];
  logic [15:0] m_sq [2];
  logic [2:0]  m_en [2];

  ts_cap_top dut_i (
    .clk(clk), .rst_n(rst_n), .time_cnt(time_cnt),
    .rx_evt(rx_evt), .rx_cls(rx_cls), .rx_seq(rx_seq),
    .tx_evt(tx_evt), .tx_cls(tx_cls), .tx_seq(tx_seq),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit qual(logic [2:0] en, logic [1:0] cls);
    return (cls < 2'd3) && en[cls];
  endfunction

  function automatic logic [31:0] exp_reg(int d, logic [1:0] r);
    case (r)
      2'd0: return {15'd0, m_v[d], m_sq[d]};
      2'd1: return m_ts[d][31:0];
      2'd2: return m_ts[d][63:32];
      default: return {29'd0, m_en[d]};
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // read a register combinationally, no clock consumed
  task automatic rd(logic [2:0] a, output logic [31:0] v);
    host_wr = 1'b0; host_addr = a; #1; v = host_rdata;
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    for (int d = 0; d < 2; d++) begin
      for (int r = 0; r < 4; r++) begin
        rd(3'(d*4 + r), v);
        chk(tag, v, exp_reg(d, 2'(r)));
      end
    end
  endtask

  // one clock cycle with given stimulus, model updated alongside
  task automatic step(bit wr, logic [2:0] a, logic [31:0] wd,
                      bit re, logic [1:0] rc, logic [15:0] rs,
                      bit te, logic [1:0] tc, logic [15:0] ts,
                      logic [63:0] tm);
    bit ev [2]; logic [1:0] cl [2]; logic [15:0] sq [2];
    host_wr = wr; host_addr = a; host_wdata = wd;
    rx_evt = re; rx_cls = rc; rx_seq = rs;
    tx_evt = te; tx_cls = tc; tx_seq = ts; time_cnt = tm;
    ev[0] = re; ev[1] = te; cl[0] = rc; cl[1] = tc; sq[0] = rs; sq[1] = ts;
    @(posedge clk);
    for (int d = 0; d < 2; d++) begin
      bit clr, cap;
      clr = wr && a == 3'(d*4) && wd[16];
      cap = ev[d] && qual(m_en[d], cl[d]) && (!m_v[d] || clr);
      if (cap) begin m_v[d] = 1; m_ts[d] = tm; m_sq[d] = sq[d]; end
      else if (clr) m_v[d] = 0;
      if (wr && a == 3'(d*4 + 3)) m_en[d] = wd[2:0];
    end
    #1;
    host_wr = 0; rx_evt = 0; tx_evt = 0;
  endtask

  task automatic idle();
    step(0, 3'd0, 32'd0, 0, 2'd0, 16'd0, 0, 2'd0, 16'd0, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    for (int d = 0; d < 2; d++) begin m_v[d] = 0; m_ts[d] = 0; m_sq[d] = 0; m_en[d] = 0; end
    rst_n = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    rx_evt = 0; tx_evt = 0; rx_cls = 0; tx_cls = 0; rx_seq = 0; tx_seq = 0; time_cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    check_all("R1 reset");

    // R7: disabled mask ignores events
    step(0, 0, 0, 1, 2'd1, 16'h1111, 1, 2'd0, 16'h2222, 64'hA);
    rd(3'd0, v); chk("R7 disabled rx", v, 32'h0);
    rd(3'd4, v); chk("R7 disabled tx", v, 32'h0);

    // R9: enable readback drops upper bits
    step(1, 3'd3, 32'hFFFF_FFF5, 0, 0, 0, 0, 0, 0, 0);
    rd(3'd3, v); chk("R9 rx enable", v, 32'h5);
    step(1, 3'd3, 32'h7, 0, 0, 0, 0, 0, 0, 0);
    rd(3'd3, v); chk("R9 rx enable all", v, 32'h7);

    // R2/R3: capture on rx, R8: tx untouched
    step(0, 0, 0, 1, 2'd1, 16'h1234, 0, 0, 0, 64'h0123_4567_89AB_CDEF);
    rd(3'd0, v); chk("R3 status", v, 32'h0001_1234);
    rd(3'd1, v); chk("R2 low", v, 32'h89AB_CDEF);
    rd(3'd2, v); chk("R2 high", v, 32'h0123_4567);
    rd(3'd4, v); chk("R8 tx status", v, 32'h0);

    // R4: later event ignored
    step(0, 0, 0, 1, 2'd2, 16'h5555, 0, 0, 0, 64'hFFFF_0000_FFFF_0000);
    rd(3'd0, v); chk("R4 status held", v, 32'h0001_1234);
    rd(3'd1, v); chk("R4 low held", v, 32'h89AB_CDEF);

    // R5: write without bit 16 does nothing, with bit 16 clears
    step(1, 3'd0, 32'hFFFE_FFFF, 0, 0, 0, 0, 0, 0, 0);
    rd(3'd0, v); chk("R5 no clear", v, 32'h0001_1234);
    step(1, 3'd0, 32'h0001_0000, 0, 0, 0, 0, 0, 0, 0);
    rd(3'd0, v); chk("R5 cleared", v, 32'h0000_1234);

    // R6: refill, then clear and event collide
    step(0, 0, 0, 1, 2'd0, 16'h0AAA, 0, 0, 0, 64'h11);
    step(1, 3'd0, 32'h0001_0000, 1, 2'd0, 16'h0777, 0, 0, 0, 64'hDEAD_BEEF_0000_0042);
    rd(3'd0, v); chk("R6 status", v, 32'h0001_0777);
    rd(3'd1, v); chk("R6 low", v, 32'h0000_0042);
    rd(3'd2, v); chk("R6 high", v, 32'hDEAD_BEEF);

    // R7: per-class mask and class 3
    step(1, 3'd0, 32'h0001_0000, 0, 0, 0, 0, 0, 0, 0);
    step(1, 3'd3, 32'h2, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 2'd0, 16'h0001, 0, 0, 0, 64'h1);
    step(0, 0, 0, 1, 2'd3, 16'h0003, 0, 0, 0, 64'h3);
    rd(3'd0, v); chk("R7 class masked", v, 32'h0000_0777);
    step(0, 0, 0, 1, 2'd1, 16'h0002, 0, 0, 0, 64'h2);
    rd(3'd0, v); chk("R7 class enabled", v, 32'h0001_0002);

    // R8: tx capture and clear leave rx alone
    step(1, 3'd7, 32'h7, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 2'd2, 16'hBEEF, 64'h77);
    rd(3'd4, v); chk("R8 tx status", v, 32'h0001_BEEF);
    step(1, 3'd4, 32'h0001_0000, 0, 0, 0, 0, 0, 0, 0);
    rd(3'd0, v); chk("R8 rx kept", v, 32'h0001_0002);
    check_all("R8 all");

    // random phase with frequent clear/event collisions
    for (int i = 0; i < 400; i++) begin
      bit wr; logic [2:0] a; logic [31:0] wd;
      wr = ($urandom % 3) == 0;
      a  = 3'($urandom % 8);
      wd = $urandom;
      if (a[1:0] == 2'd0) wd[16] = ($urandom % 4) != 0;
      step(wr, a, wd,
           ($urandom % 2) == 1, 2'($urandom), 16'($urandom),
           ($urandom % 2) == 1, 2'($urandom), 16'($urandom),
           {$urandom, $urandom});
      check_all("R6 random");
    end

    idle();
    check_all("R4 final");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule